// File: doc/BRIEF.md
# Four-Channel Converter Host Register Block

This block is the processor-side control and status logic of a four-input converter that can produce either 8-bit or 12-bit samples. A host on an 8-bit bus reaches it through three offsets. Writing offset 0 selects an input channel and a resolution, and starts a conversion at once. A timer then runs for a fixed number of clock cycles, chosen by the resolution. When it expires, the block latches the sample presented for the selected channel and raises a one-cycle end-of-conversion interrupt.

Offset 0 also serves as the status byte on read. The status byte shows the busy state, the selected channel, the resolution and the top two bits of the last result. A start written while a conversion is still in progress cancels that conversion and begins a new one. The result registers keep the last completed sample until the next conversion finishes. Reads are combinational on the offset. The per-channel sample port is a plain level input, taken on the completion edge, so there is no handshake and no back-pressure at any edge of the block. The digital value on that port stands in for the analogue front end and the comparator.

Top module: `adc_host_regs`

## Requirements
- R1: After reset, a read of offset 0 returns 0x40 (idle, complete, channel 0, 8-bit mode). Offsets 1 and 2 read 0x00, and `eoc_irq` is low.
- R2: A write to offset 0 starts a conversion in the next cycle. Status bit 7 reads 1 and bit 6 reads 0 while the conversion runs. Bits 1-0 report the written channel and bit 3 the written resolution (0 = 8-bit, 1 = 12-bit). Written bits 7-4 and bit 2 are ignored, and status bit 2 always reads 0.
- R3: A conversion keeps status bit 7 at 1 for exactly `CYC_LO` cycles in 8-bit mode, or `CYC_HI` cycles in 12-bit mode, and then clears it.
- R4: On completion, the 12-bit sample of the selected channel is latched. Offset 1 reads sample bits 11-4. Offset 2 reads sample bits 3-0 in its bits 7-4, with bits 3-0 reading 0.
- R5: A conversion completed in 8-bit mode stores zeros in result bits 3-0, so offset 2 reads 0x00.
- R6: Status bits 5-4 always equal bits 11-10 of the stored result.
- R7: `eoc_irq` is high for exactly one cycle, the first cycle in which status bit 7 reads 0 after a conversion. It is never high at any other time.
- R8: A write to offset 0 while busy abandons the running conversion without an interrupt. It restarts the timer with the new channel and the new resolution.
- R9: The stored result changes only when a conversion completes. An abandoned conversion and writes to offsets 1 and 2 leave it unchanged.
- R10: A read of offset 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sample_in | input | NCH*12 | Per-channel digital samples, channel 0 in the low 12 bits |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |

## Verification
The bench builds the block with `CYC_LO` = 12 and `CYC_HI` = 30. At these values every conversion can be timed exactly, cycle by cycle, against the resolution of its start word. Aborts can land early or late in a run, and many conversions of both resolutions fit in a short run. Four channels with random samples show that the selected channel is the one captured. Random junk in the ignored command bits, and stray writes to the result offsets, show that neither of them disturbs the state.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int RES_W = 12;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    OFF_CTRL = 2'd0,
    OFF_HI   = 2'd1,
    OFF_LO   = 2'd2,
    OFF_NONE = 2'd3
  } reg_off_e;

  typedef enum logic {
    RES_8  = 1'b0,
    RES_12 = 1'b1
  } res_e;

  typedef struct packed {
    logic [1:0] chan;
    res_e       res;
  } start_cmd_t;
endpackage

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
  import adc_pkg::*;
(
  input  logic             bus_wr_en,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic             start_vld,
  output start_cmd_t       start_cmd
);
  logic unused_bits;
  assign unused_bits = ^{bus_wdata[7:4], bus_wdata[2]};

  always_comb begin
    start_vld      = bus_wr_en && (reg_off_e'(bus_addr) == OFF_CTRL);
    start_cmd.chan = bus_wdata[1:0];
    start_cmd.res  = res_e'(bus_wdata[3]);
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_pkg::*;
#(
  parameter int CYC_LO = 8000,
  parameter int CYC_HI = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_vld,
  input  res_e start_res,
  output logic busy,
  output logic finish,
  output logic eoc_irq
);
  localparam int CNT_W = $clog2(CYC_HI + 1);

  logic [CNT_W-1:0] cnt_q;

  // A start arriving in the last cycle wins over completion.
  assign finish = busy && (cnt_q == CNT_W'(1)) && !start_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      busy    <= 1'b0;
      eoc_irq <= 1'b0;
    end else begin
      eoc_irq <= finish;
      if (start_vld) begin
        busy  <= 1'b1;
        cnt_q <= (start_res == RES_12) ? CNT_W'(CYC_HI) : CNT_W'(CYC_LO);
      end else if (finish) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else if (busy) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
  import adc_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic [1:0]           chan,
  input  res_e                 res,
  input  logic [NCH*RES_W-1:0] sample_in,
  output logic [RES_W-1:0]     result_q
);
  localparam int LOW_BITS = RES_W - 8;
  localparam logic [RES_W-1:0] MASK8 = {{8{1'b1}}, {LOW_BITS{1'b0}}};

  logic [RES_W-1:0] samp_arr [NCH];
  logic [RES_W-1:0] picked;

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign samp_arr[g] = sample_in[g*RES_W +: RES_W];
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < NCH; i++) begin
      if (chan == 2'(i)) picked = samp_arr[i];
    end
    if (res == RES_8) picked = picked & MASK8;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else if (capture) result_q <= picked;
  end
endmodule

// File: rtl/adc_host_regs.sv
module adc_host_regs
  import adc_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CYC_LO = 8000,
  parameter int CYC_HI = 20000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_en,
  input  logic [1:0]           bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic [NCH*12-1:0]    sample_in,
  output logic                 eoc_irq
);
  logic             start_vld;
  start_cmd_t       start_cmd;
  logic [1:0]       chan_q;
  res_e             res_q;
  logic             busy;
  logic             finish;
  logic [RES_W-1:0] result_q;
  logic [7:0]       status;

  adc_cmd_decode u_dec (
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .start_vld (start_vld),
    .start_cmd (start_cmd)
  );

  adc_conv_seq #(.CYC_LO(CYC_LO), .CYC_HI(CYC_HI)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_vld (start_vld),
    .start_res (start_cmd.res),
    .busy      (busy),
    .finish    (finish),
    .eoc_irq   (eoc_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      res_q  <= RES_8;
    end else if (start_vld) begin
      chan_q <= start_cmd.chan;
      res_q  <= start_cmd.res;
    end
  end

  adc_result_store #(.NCH(NCH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (finish),
    .chan      (chan_q),
    .res       (res_q),
    .sample_in (sample_in),
    .result_q  (result_q)
  );

  assign status = {busy, ~busy, result_q[RES_W-1 -: 2], res_q, 1'b0, chan_q};

  always_comb begin
    unique case (reg_off_e'(bus_addr))
      OFF_CTRL: bus_rdata = status;
      OFF_HI:   bus_rdata = result_q[RES_W-1 -: 8];
      OFF_LO:   bus_rdata = {result_q[RES_W-9:0], 4'b0000};
      default:  bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/adc_host_regs_chk.sv
module adc_host_regs_chk
  import adc_pkg::*;
#(
  parameter int CYC_HI = 20000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_vld,
  input logic             busy,
  input logic             eoc_irq,
  input logic [RES_W-1:0] result,
  input res_e             res_sel
);
  localparam int LEN_W = $clog2(CYC_HI + 2);
  logic [LEN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (start_vld) run_len <= LEN_W'(1);
    else if (busy) run_len <= run_len + LEN_W'(1);
    else run_len <= '0;
  end

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_vld |=> busy);

  // R3
  run_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len <= LEN_W'(CYC_HI)));

  // R7
  irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> eoc_irq);

  // R7
  irq_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> (!busy && $past(busy)));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> eoc_irq);

  // R5
  low_zero_8b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_irq && res_sel == RES_8) |-> (result[3:0] == 4'h0));
endmodule

bind adc_host_regs adc_host_regs_chk #(.CYC_HI(CYC_HI)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_vld (start_vld),
  .busy      (busy),
  .eoc_irq   (eoc_irq),
  .result    (result_q),
  .res_sel   (res_q)
);

// File: tb/adc_host_regs_tb.sv
module adc_host_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CYC_LO = 12;
  localparam int CYC_HI = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr_en = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [NCH*12-1:0] sample_in;
  logic eoc_irq;

  logic [11:0] samp [NCH];
  logic [11:0] last_res;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) sample_in[i*12 +: 12] = samp[i];
  end

  adc_host_regs #(.NCH(NCH), .CYC_LO(CYC_LO), .CYC_HI(CYC_HI)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_in(sample_in),
    .eoc_irq(eoc_irq)
  );

  function automatic logic [11:0] exp_store(logic [11:0] s, logic res);
    return res ? s : {s[11:4], 4'h0};
  endfunction

  function automatic logic [7:0] exp_status(logic bsy, logic [11:0] r, logic res, logic [1:0] ch);
    return {bsy, ~bsy, r[11:10], res, 1'b0, ch};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic check_results(string req);
    logic [7:0] d;
    rd(2'd1, d); check({req, " hi"}, 32'(d), 32'(last_res[11:4]));
    rd(2'd2, d); check({req, " lo"}, 32'(d), 32'({last_res[3:0], 4'h0}));
  endtask

  // Starts a conversion and follows it to its end.
  task automatic run_conv(logic [7:0] cmd);
    logic [7:0] st;
    int n;
    logic res;
    logic [1:0] ch;
    res = cmd[3]; ch = cmd[1:0];
    bus_write(2'd0, cmd);
    rd(2'd0, st);
    check("R2 status at start", 32'(st), 32'(exp_status(1'b1, last_res, res, ch)));
    n = 0;
    while (n < 1000) begin
      rd(2'd0, st);
      if (!st[7]) break;
      n++;
      if (eoc_irq) check("R7 irq while busy", 32'(eoc_irq), 32'd0);
      @(negedge clk);
    end
    check("R3 duration", 32'(n), 32'(res ? CYC_HI : CYC_LO));
    check("R7 irq at finish", 32'(eoc_irq), 32'd1);
    last_res = exp_store(samp[ch], res);
    rd(2'd0, st);
    check("R6 status after finish", 32'(st), 32'(exp_status(1'b0, last_res, res, ch)));
    check_results(res ? "R4" : "R5");
    @(negedge clk);
    check("R7 irq single cycle", 32'(eoc_irq), 32'd0);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < NCH; i++) samp[i] = 12'h000;
    last_res = 12'h000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 status", 32'(d), 32'h40);
    rd(2'd1, d); check("R1 hi", 32'(d), 32'h00);
    rd(2'd2, d); check("R1 lo", 32'(d), 32'h00);
    check("R1 irq", 32'(eoc_irq), 32'd0);
    rd(2'd3, d); check("R10 offset 3", 32'(d), 32'h00);

    // Directed: 12-bit, junk in ignored bits (R2)
    samp[0] = 12'h123; samp[1] = 12'h456; samp[2] = 12'hABC; samp[3] = 12'hFFF;
    run_conv(8'hFE);
    run_conv(8'h53);
    run_conv(8'h08);

    // R9: writes to result offsets ignored
    bus_write(2'd1, 8'h5A);
    bus_write(2'd2, 8'hA5);
    check_results("R9 result offsets write");
    rd(2'd3, d); check("R10 offset 3 after", 32'(d), 32'h00);

    // R8 abort: start 12-bit ch1, abort with 8-bit ch3
    samp[1] = 12'h7E1; samp[3] = 12'h9C5;
    bus_write(2'd0, 8'h09);
    repeat (5) begin
      check("R8 no irq during aborted run", 32'(eoc_irq), 32'd0);
      check_results("R9 held during run");
      @(negedge clk);
    end
    samp[1] = 12'h000;
    run_conv(8'h03);

    // R8 abort late in a run
    bus_write(2'd0, 8'h02);
    repeat (CYC_LO - 2) @(negedge clk);
    check("R8 no irq before late abort", 32'(eoc_irq), 32'd0);
    run_conv(8'h0A);

    // Constrained random
    for (int k = 0; k < 40; k++) begin
      logic [7:0] cmd;
      for (int i = 0; i < NCH; i++) samp[i] = 12'($urandom);
      cmd = 8'($urandom);
      if (($urandom % 4) == 0) begin
        bus_write(2'd1 + 2'($urandom % 2), 8'($urandom));
        check_results("R9 random stray write");
      end
      run_conv(cmd);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule